// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block walks the chain of extended capability headers stored in the upper part of a 4 KB configuration space. It reads the space one dword at a time through a synchronous single-port memory. Each header dword carries a 16-bit capability identifier, a 4-bit version and a 12-bit byte offset to the next header. A find command follows the chain from the fixed head until it reaches the requested identifier or the end of the chain. It returns the byte offset of the match and the offset of the entry visited just before it.

An append command places a new header at a given offset. It first runs the same walk with an identifier that can never match, which locates the tail. It then rewrites only the next-offset field of the old tail so that it points at the new header. Last, it writes the new header with a zero next field. When the new header sits at the head itself, no tail is linked. The walker checks each pointer it follows for bounds and alignment. It also stops after a fixed number of hops, so a corrupted circular chain cannot hang it.

Top module: `ecap_walker`

## Requirements
- R1: A header dword holds the identifier in bits 15:0, the version in bits 19:16 and the next byte offset in bits 31:20. A next offset of zero ends the chain.
- R2: If the header dword at the head offset 0x100 is all zero, a find completes with found offset 0, previous offset 0 and no error.
- R3: A find for an identifier present in the chain completes with the byte offset of its first occurrence. The previous offset is the entry visited before it, or 0 when the match is at the head.
- R4: A find for an identifier absent from a non-empty chain completes without error. It returns found offset 0 and, as previous offset, the offset of the last entry in the chain.
- R5: A next offset below 0x100, above 0xFF8, or not a multiple of 4 ends the command with the error flag set. No memory read is ever issued outside dword addresses 0x40 to 0x3FE.
- R6: A walk that has visited MAX_HOPS entries without reaching a match or the end of the chain stops with the error flag set.
- R7: An append at offset 0x100 writes only the new header {next=0, version, identifier} at that offset. It reports previous offset 0.
- R8: An append at any other offset replaces only bits 31:20 of the tail header with the new offset, keeping the tail's identifier and version. It then writes the new header with next field 0, and reports the new offset and the tail offset.
- R9: An append whose offset is below 0x100 or not a multiple of 4, whose size is below 8, or whose offset plus size exceeds 4096 ends with the error flag set. It writes no memory.
- R10: An append at an offset other than 0x100 into an empty chain ends with the error flag set. It writes no memory.
- R11: After reset, busy and done are low. An accepted command raises busy on the next cycle. Done is high for exactly one cycle per command, and the error flag and offsets hold their values until the next command is accepted.
- R12: A command presented while busy is ignored. It produces no extra done pulse and no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_append | input | 1 | 1 = append, 0 = find |
| cmd_id | input | 16 | Identifier to find or to write |
| cmd_ver | input | 4 | Version of an appended header |
| cmd_offset | input | 12 | Byte offset of an appended header |
| cmd_size | input | 13 | Byte length of an appended region |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last command failed |
| found_offset | output | 12 | Match offset (find) or new offset (append) |
| prev_offset | output | 12 | Preceding or tail entry offset |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 10 | Dword address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read |

## Verification
Finds are tried against an empty chain, on the head entry, on a middle entry, on the tail entry and on an absent identifier. Together they separate the match path from the end-of-chain path, and they show that the previous offset follows one step behind. Appends are made at the head, after a single entry and after two entries, and the memory is read back each time. This shows that only the tail's next field changes. Corrupted chains cover three cases: an unaligned pointer, pointers that fall just outside the allowed range on each side, and a circular chain. Each one must raise the error flag, and the circular one must do so through the hop limit rather than hang. A command issued mid-walk shows that a busy walker ignores new commands.

// File: rtl/ecap_walker.sv
module ecap_walker #(
  parameter logic [11:0] HEAD_OFF = 12'h100,
  parameter logic [11:0] LAST_OFF = 12'hFF8,
  parameter int          MAX_HOPS = 1024,
  localparam int         HOP_W    = $clog2(MAX_HOPS) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_append,
  input  logic [15:0] cmd_id,
  input  logic [3:0]  cmd_ver,
  input  logic [11:0] cmd_offset,
  input  logic [12:0] cmd_size,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic [11:0] found_offset,
  output logic [11:0] prev_offset,
  output logic        mem_en,
  output logic        mem_we,
  output logic [9:0]  mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_DECODE, S_LINK, S_PUT, S_FIN} st_t;
  st_t state;

  logic        op_app;
  logic [16:0] tgt;
  logic [15:0] new_id;
  logic [3:0]  new_ver;
  logic [11:0] new_off, cur, prv;
  logic [31:0] hdr;
  logic [HOP_W-1:0] hops;

  wire [11:0] nxt = hdr[31:20];
  wire [13:0] end_pos = {2'b00, cmd_offset} + {1'b0, cmd_size};
  wire bad_region = (cmd_offset < HEAD_OFF) || (cmd_offset[1:0] != 2'b00) ||
                    (cmd_size < 13'd8) || (end_pos > 14'd4096);
  wire bad_next = (nxt < HEAD_OFF) || (nxt > LAST_OFF) || (nxt[1:0] != 2'b00);

  assign busy      = state != S_IDLE;
  assign done      = state == S_FIN;
  assign mem_en    = (state == S_ISSUE) || (state == S_LINK) || (state == S_PUT);
  assign mem_we    = (state == S_LINK) || (state == S_PUT);
  assign mem_addr  = (state == S_PUT) ? new_off[11:2] : cur[11:2];
  assign mem_wdata = (state == S_LINK) ? {new_off, hdr[19:0]} : {12'h000, new_ver, new_id};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op_app <= 1'b0;
      tgt <= '0;
      new_id <= '0;
      new_ver <= '0;
      new_off <= '0;
      cur <= '0;
      prv <= '0;
      hdr <= '0;
      hops <= '0;
      error <= 1'b0;
      found_offset <= '0;
      prev_offset <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          op_app <= cmd_append;
          tgt <= cmd_append ? 17'h10000 : {1'b0, cmd_id};
          new_id <= cmd_id;
          new_ver <= cmd_ver;
          new_off <= cmd_offset;
          cur <= HEAD_OFF;
          prv <= '0;
          hops <= '0;
          error <= 1'b0;
          found_offset <= '0;
          prev_offset <= '0;
          if (!cmd_append) state <= S_ISSUE;
          else if (bad_region) begin
            error <= 1'b1;
            state <= S_FIN;
          end else if (cmd_offset == HEAD_OFF) begin
            found_offset <= cmd_offset;
            state <= S_PUT;
          end else state <= S_ISSUE;
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: begin
          hdr <= mem_rdata;
          state <= S_DECODE;
        end
        S_DECODE: begin
          if (cur == HEAD_OFF && hdr == 32'h0) begin
            error <= op_app;
            state <= S_FIN;
          end else if ({1'b0, hdr[15:0]} == tgt) begin
            found_offset <= cur;
            prev_offset <= prv;
            state <= S_FIN;
          end else if (nxt == 12'h000) begin
            prev_offset <= cur;
            if (op_app) begin
              found_offset <= new_off;
              state <= S_LINK;
            end else state <= S_FIN;
          end else if (bad_next || hops == HOP_W'(MAX_HOPS - 1)) begin
            error <= 1'b1;
            state <= S_FIN;
          end else begin
            prv <= cur;
            cur <= nxt;
            hops <= hops + 1'b1;
            state <= S_ISSUE;
          end
        end
        S_LINK: state <= S_PUT;
        S_PUT: state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecap_walker_chk.sv
module ecap_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        busy,
  input logic        done,
  input logic        error,
  input logic [11:0] found_offset,
  input logic [11:0] prev_offset,
  input logic        mem_en,
  input logic        mem_we,
  input logic [9:0]  mem_addr
);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);
  p_read_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> (mem_addr >= 10'h040 && mem_addr <= 10'h3FE));
  p_write_in_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  p_aligned_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> (found_offset[1:0] == 2'b00 && prev_offset[1:0] == 2'b00));
endmodule

bind ecap_walker ecap_walker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .error(error), .found_offset(found_offset), .prev_offset(prev_offset),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/ecap_walker_tb_top.sv
module ecap_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_append = 1'b0;
  logic [15:0] cmd_id = '0;
  logic [3:0]  cmd_ver = '0;
  logic [11:0] cmd_offset = '0;
  logic [12:0] cmd_size = '0;
  logic        busy, done, error, mem_en, mem_we;
  logic [11:0] found_offset, prev_offset;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem [1024];
  logic        tb_clr = 1'b0, tb_we = 1'b0;
  logic [9:0]  tb_addr = '0;
  logic [31:0] tb_wd = '0;

  int total = 0, bad = 0, wrt = 0;

  ecap_walker dut_i (.*);

  always_ff @(posedge clk) begin
    if (tb_clr) begin
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
    end else if (tb_we) mem[tb_addr] <= tb_wd;
    else if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= mem[mem_addr];
    if (mem_en && mem_we) wrt <= wrt + 1;
  end

  function automatic logic [31:0] hdr(input logic [15:0] id, input logic [3:0] v, input logic [11:0] nx);
    return {nx, v, id};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic clear_mem();
    @(negedge clk); tb_clr = 1'b1;
    @(negedge clk); tb_clr = 1'b0;
  endtask

  task automatic poke(input logic [11:0] off, input logic [31:0] d);
    @(negedge clk); tb_we = 1'b1; tb_addr = off[11:2]; tb_wd = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic run(input logic app, input logic [15:0] id, input logic [3:0] v,
                     input logic [11:0] off, input logic [12:0] sz);
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_append = app; cmd_id = id; cmd_ver = v; cmd_offset = off; cmd_size = sz;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk("watchdog", 32'd0, 32'd1);
  endtask

  task automatic t_reset();
    chk("R11 busy after reset", {31'd0, busy}, 32'd0);
    chk("R11 done after reset", {31'd0, done}, 32'd0);
  endtask

  task automatic t_empty();
    clear_mem();
    run(1'b0, 16'h0001, 4'd0, 12'h0, 13'd0);
    chk("R2 empty found", {20'd0, found_offset}, 32'h0);
    chk("R2 empty prev", {20'd0, prev_offset}, 32'h0);
    chk("R2 empty error", {31'd0, error}, 32'd0);
    @(negedge clk);
    chk("R11 done single cycle", {31'd0, done}, 32'd0);
    chk("R11 result held", {20'd0, prev_offset}, 32'h0);
    run(1'b1, 16'h0005, 4'd1, 12'h180, 13'd16);
    chk("R10 append to empty error", {31'd0, error}, 32'd1);
    chk("R10 no write", mem[12'h180 >> 2], 32'h0);
  endtask

  task automatic t_build();
    run(1'b1, 16'h0001, 4'd2, 12'h100, 13'd8);
    chk("R7 head header", mem[12'h100 >> 2], hdr(16'h0001, 4'd2, 12'h0));
    chk("R7 head prev", {20'd0, prev_offset}, 32'h0);
    chk("R7 head error", {31'd0, error}, 32'd0);
    run(1'b1, 16'h0010, 4'd1, 12'h140, 13'd16);
    chk("R8 tail relinked", mem[12'h100 >> 2], hdr(16'h0001, 4'd2, 12'h140));
    chk("R8 new header", mem[12'h140 >> 2], hdr(16'h0010, 4'd1, 12'h0));
    chk("R8 tail reported", {20'd0, prev_offset}, 32'h100);
    run(1'b1, 16'h0003, 4'd3, 12'h200, 13'd64);
    chk("R8 second relink", mem[12'h140 >> 2], hdr(16'h0010, 4'd1, 12'h200));
    chk("R8 second header", mem[12'h200 >> 2], hdr(16'h0003, 4'd3, 12'h0));
    chk("R8 new offset", {20'd0, found_offset}, 32'h200);
    chk("R1 head untouched", mem[12'h100 >> 2], hdr(16'h0001, 4'd2, 12'h140));
  endtask

  task automatic t_find();
    run(1'b0, 16'h0010, 4'd0, 12'h0, 13'd0);
    chk("R3 middle found", {20'd0, found_offset}, 32'h140);
    chk("R3 middle prev", {20'd0, prev_offset}, 32'h100);
    run(1'b0, 16'h0003, 4'd0, 12'h0, 13'd0);
    chk("R3 tail found", {20'd0, found_offset}, 32'h200);
    chk("R3 tail prev", {20'd0, prev_offset}, 32'h140);
    run(1'b0, 16'h0001, 4'd0, 12'h0, 13'd0);
    chk("R3 head found", {20'd0, found_offset}, 32'h100);
    chk("R3 head prev", {20'd0, prev_offset}, 32'h0);
    run(1'b0, 16'h7777, 4'd0, 12'h0, 13'd0);
    chk("R4 absent found", {20'd0, found_offset}, 32'h0);
    chk("R4 absent prev", {20'd0, prev_offset}, 32'h200);
    chk("R4 absent error", {31'd0, error}, 32'd0);
  endtask

  task automatic t_bad_append();
    int w0;
    w0 = wrt;
    run(1'b1, 16'h0009, 4'd1, 12'hFFC, 13'd8);
    chk("R9 past end error", {31'd0, error}, 32'd1);
    run(1'b1, 16'h0009, 4'd1, 12'h300, 13'd4);
    chk("R9 short size error", {31'd0, error}, 32'd1);
    run(1'b1, 16'h0009, 4'd1, 12'h0F0, 13'd8);
    chk("R9 below head error", {31'd0, error}, 32'd1);
    run(1'b1, 16'h0009, 4'd1, 12'h302, 13'd8);
    chk("R9 unaligned error", {31'd0, error}, 32'd1);
    run(1'b1, 16'h0009, 4'd1, 12'hFF8, 13'd8);
    chk("R9 exact fit ok", {31'd0, error}, 32'd0);
    chk("R9 rejected writes none", wrt - w0, 32'd2);
    chk("R9 tail unchanged by rejects", mem[12'h200 >> 2], hdr(16'h0003, 4'd3, 12'hFF8));
  endtask

  task automatic t_corrupt();
    poke(12'h200, hdr(16'h0003, 4'd3, 12'h202));
    run(1'b0, 16'h9999, 4'd0, 12'h0, 13'd0);
    chk("R5 unaligned next error", {31'd0, error}, 32'd1);
    poke(12'h200, hdr(16'h0003, 4'd3, 12'h0FC));
    run(1'b0, 16'h9999, 4'd0, 12'h0, 13'd0);
    chk("R5 low next error", {31'd0, error}, 32'd1);
    poke(12'h200, hdr(16'h0003, 4'd3, 12'hFFC));
    run(1'b0, 16'h9999, 4'd0, 12'h0, 13'd0);
    chk("R5 high next error", {31'd0, error}, 32'd1);
    poke(12'h200, hdr(16'h0003, 4'd3, 12'h100));
    run(1'b0, 16'h9999, 4'd0, 12'h0, 13'd0);
    chk("R6 circular chain error", {31'd0, error}, 32'd1);
    run(1'b0, 16'h0003, 4'd0, 12'h0, 13'd0);
    chk("R6 match in circular chain", {20'd0, found_offset}, 32'h200);
  endtask

  task automatic t_busy_ignore();
    int w0, pulses;
    poke(12'h200, hdr(16'h0003, 4'd3, 12'h0));
    w0 = wrt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_append = 1'b0; cmd_id = 16'h4444;
    @(negedge clk);
    cmd_append = 1'b1; cmd_id = 16'h0022; cmd_offset = 12'h300; cmd_size = 13'd8;
    @(negedge clk);
    cmd_valid = 1'b0;
    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      if (done) pulses++;
      @(negedge clk);
    end
    chk("R12 single done", pulses, 32'd1);
    chk("R12 no writes", wrt - w0, 32'd0);
    chk("R12 find result kept", {20'd0, prev_offset}, 32'h200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_build();
    t_find();
    t_bad_append();
    t_corrupt();
    t_busy_ignore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule